// File: doc/BRIEF.md
# Merge Select-Op Generator

This rename-stage block closes a dynamically predicated region. It keeps the active register map, one modified bit per map entry, and two snapshots: the map as it stood when the predicted path was entered, and the map as it stood when that path ended. When the alternate path begins, the entry snapshot is copied back into the active map. The alternate path is therefore renamed against the values from before the branch.

When the region-exit marker arrives, the block ORs the modified bits of the end-of-predicted-path snapshot with those of the active map. It then walks the set registers from the lowest index upward, up to `SEL_PORTS` per cycle. For each register it issues one select operation. The select carries the physical register from each path and the predicate id captured at region entry. It is given a destination taken from the free list, and that destination is written into the active map. Rename is stalled until the walk ends. The free list and the execution of the selects belong to neighbouring blocks.

Top module: `mergeSelGen`

## Requirements
- R1: After reset, the active map holds physical register i for architectural register i. `renStall`, `mergeDone` and every `selValid` bit are low.
- R2: An enter-predicted pulse in idle clears every modified bit and captures `enterPredId`. A rename write during either path sets the entry's modified bit. A rename write in idle sets no modified bit, so it never produces a select.
- R3: An enter-alternate pulse during the predicted path snapshots the active map and its modified bits. In the same cycle it copies the entry snapshot into the active map, so `rdPhys` returns the pre-region mapping.
- R4: An exit pulse during the alternate path issues exactly one select for every register whose modified bit is set in either map. Each select carries the end-of-predicted-path physical register on `selSrcPred` and the active physical register on `selSrcAlt`. `selPredId` carries the predicate id captured at entry.
- R5: At most `SEL_PORTS` selects are issued per cycle, in ascending register order, with port 0 holding the lowest register. Port k issues only if ports 0 to k-1 issue in that cycle.
- R6: Port k's destination is free slot k (`selDst` equals `freePhys` slot k, and `freeTake[k]` is high). From the next cycle the active map holds that destination for the register, and no second select is issued for it.
- R7: `renStall` is high in every merge cycle. `mergeDone` pulses in the cycle of the last select, and the block returns to idle in the next cycle.
- R8: An exit with no modified bit set lasts one cycle: `renStall` and `mergeDone` are high for that cycle and no select is issued.
- R9: Port k issues only while `freeAvail[k]` is high. While no free register is offered, the merge waits with `renStall` high and issues nothing.
- R10: Markers given in the wrong phase are ignored. An exit or enter-alternate pulse in idle leaves the map and `renStall` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renWrEn | input | 1 | Rename write to the active map |
| renArch | input | ARCH_W | Architectural register being renamed |
| renPhys | input | PHYS_W | New physical register for it |
| enterPred | input | 1 | Enter-predicted-path marker |
| enterPredId | input | PRED_W | Predicate id for the region |
| enterAlt | input | 1 | Enter-alternate-path marker |
| exitPred | input | 1 | Region-exit marker |
| freeAvail | input | SEL_PORTS | Free slot k holds a valid register (contiguous from bit 0) |
| freePhys | input | SEL_PORTS*PHYS_W | Free register offered in each slot |
| rdArch | input | ARCH_W | Map read index |
| rdPhys | output | PHYS_W | Active mapping of `rdArch` |
| selValid | output | SEL_PORTS | Select issued on port k |
| selArch | output | SEL_PORTS*ARCH_W | Register merged on port k |
| selSrcPred | output | SEL_PORTS*PHYS_W | Physical register at end of predicted path |
| selSrcAlt | output | SEL_PORTS*PHYS_W | Physical register at end of alternate path |
| selDst | output | SEL_PORTS*PHYS_W | Destination given to the select |
| selPredId | output | PRED_W | Predicate id steering the selects |
| freeTake | output | SEL_PORTS | Free slot k consumed this cycle |
| renStall | output | 1 | Rename must hold |
| mergeDone | output | 1 | Last cycle of a merge |

## Verification
The assertions rely on the markers arriving in order: enter-predicted, then enter-alternate, then exit. They assume no rename write accompanies a marker, and that `freeAvail` is contiguous from slot 0. The stimulus follows this order in every region and drives only the all-free, lowest-slot-only and no-free patterns. It also sends out-of-phase markers from idle only, where the block must discard them. Scenarios cover a path that writes a register twice, registers written on one path only or on both paths, a region with no writes, and a merge starved of free registers.

// File: rtl/mergeSelPkg.sv
package mergeSelPkg;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_PRED  = 2'd1,
    MS_ALT   = 2'd2,
    MS_MERGE = 2'd3
  } mergeState_e;

  // strobes from control to the map datapath
  typedef struct packed {
    logic renWr;      // write the active map
    logic markMod;    // also set the modified bit
    logic snapEntry;  // snapshot for the predicted path, clear modified bits
    logic snapAlt;    // snapshot end of predicted path, restore entry snapshot
  } mapStrobe_t;

endpackage

// File: rtl/mergeSelPick.sv
module mergeSelPick #(
  parameter int ARCH_REGS = 8,
  parameter int SEL_PORTS = 2,
  parameter int ARCH_W    = $clog2(ARCH_REGS)
) (
  input  logic [ARCH_REGS-1:0]                reqMask,
  output logic [SEL_PORTS-1:0]                pickValid,
  output logic [SEL_PORTS-1:0][ARCH_W-1:0]    pickArch,
  output logic [ARCH_REGS-1:0]                restMask
);

  // cascaded lowest-set-bit encoders, one per port
  always_comb begin
    logic [ARCH_REGS-1:0] remain;
    remain = reqMask;
    for (int k = 0; k < SEL_PORTS; k++) begin
      pickValid[k] = 1'b0;
      pickArch[k]  = '0;
      for (int i = ARCH_REGS - 1; i >= 0; i--) begin
        if (remain[i]) begin
          pickValid[k] = 1'b1;
          pickArch[k]  = ARCH_W'(i);
        end
      end
      if (pickValid[k]) remain[pickArch[k]] = 1'b0;
    end
    restMask = remain;
  end

endmodule

// File: rtl/mergeSelCtl.sv
module mergeSelCtl
  import mergeSelPkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int SEL_PORTS = 2,
  parameter int PRED_W    = 3,
  parameter int ARCH_W    = $clog2(ARCH_REGS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              renWrEn,
  input  logic                              enterPred,
  input  logic [PRED_W-1:0]                 enterPredId,
  input  logic                              enterAlt,
  input  logic                              exitPred,
  input  logic [SEL_PORTS-1:0]              freeAvail,
  input  logic [ARCH_REGS-1:0]              mergeMask,
  output mapStrobe_t                        strobe,
  output logic [SEL_PORTS-1:0]              fireVec,
  output logic [SEL_PORTS-1:0][ARCH_W-1:0]  fireArch,
  output logic [PRED_W-1:0]                 selPredId,
  output logic                              renStall,
  output logic                              mergeDone
);

  mergeState_e state, stateNext;
  logic [PRED_W-1:0] predIdQ;
  logic [SEL_PORTS-1:0] pickValid;
  logic [ARCH_REGS-1:0] restMask;
  logic inMerge;

  mergeSelPick #(
    .ARCH_REGS(ARCH_REGS),
    .SEL_PORTS(SEL_PORTS),
    .ARCH_W   (ARCH_W)
  ) u_pick (
    .reqMask  (mergeMask),
    .pickValid(pickValid),
    .pickArch (fireArch),
    .restMask (restMask)
  );

  assign inMerge = (state == MS_MERGE);

  always_comb begin
    strobe.renWr     = renWrEn && !inMerge;
    strobe.markMod   = renWrEn && (state == MS_PRED || state == MS_ALT);
    strobe.snapEntry = enterPred && (state == MS_IDLE);
    strobe.snapAlt   = enterAlt && (state == MS_PRED);
  end

  // in-order issue: a port fires only behind every lower port
  always_comb begin
    logic chain;
    chain = inMerge;
    for (int k = 0; k < SEL_PORTS; k++) begin
      chain      = chain && pickValid[k] && freeAvail[k];
      fireVec[k] = chain;
    end
  end

  assign mergeDone = inMerge && (restMask == '0) && (fireVec == pickValid);
  assign renStall  = inMerge;
  assign selPredId = predIdQ;

  always_comb begin
    stateNext = state;
    unique case (state)
      MS_IDLE:  if (enterPred) stateNext = MS_PRED;
      MS_PRED:  if (enterAlt)  stateNext = MS_ALT;
      MS_ALT:   if (exitPred)  stateNext = MS_MERGE;
      MS_MERGE: if (mergeDone) stateNext = MS_IDLE;
      default:  stateNext = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= MS_IDLE;
      predIdQ <= '0;
    end else begin
      state <= stateNext;
      if (strobe.snapEntry) predIdQ <= enterPredId;
    end
  end

  AST_EMPTY_EXIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) (inMerge && mergeMask == '0) |-> (mergeDone && fireVec == '0)); // R8
  AST_DONE_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rstN) mergeDone |=> (!renStall && mergeMask == '0)); // R7
  AST_FIRE_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rstN) (fireVec != '0) |-> renStall); // R7
  AST_FIRE_HAS_FREE: assert property (@(posedge clk) disable iff (!rstN) (fireVec & ~freeAvail) == '0); // R9
  AST_IDLE_EXIT_IGNORED: assert property (@(posedge clk) disable iff (!rstN) (state == MS_IDLE && !enterPred) |=> !renStall); // R10

  for (genvar k = 1; k < SEL_PORTS; k++) begin : g_order
    AST_FIRE_ASCENDING: assert property (@(posedge clk) disable iff (!rstN) fireVec[k] |-> (fireVec[k-1] && fireArch[k] > fireArch[k-1])); // R5
  end

endmodule

// File: rtl/mergeSelDp.sv
module mergeSelDp
  import mergeSelPkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int SEL_PORTS = 2,
  parameter int PHYS_W    = 6,
  parameter int ARCH_W    = $clog2(ARCH_REGS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  mapStrobe_t                        strobe,
  input  logic [ARCH_W-1:0]                 renArch,
  input  logic [PHYS_W-1:0]                 renPhys,
  input  logic [SEL_PORTS-1:0]              fireVec,
  input  logic [SEL_PORTS-1:0][ARCH_W-1:0]  fireArch,
  input  logic [SEL_PORTS-1:0][PHYS_W-1:0]  freePhys,
  input  logic [ARCH_W-1:0]                 rdArch,
  output logic [PHYS_W-1:0]                 rdPhys,
  output logic [ARCH_REGS-1:0]              mergeMask,
  output logic [SEL_PORTS-1:0][PHYS_W-1:0]  selSrcPred,
  output logic [SEL_PORTS-1:0][PHYS_W-1:0]  selSrcAlt
);

  logic [ARCH_REGS-1:0][PHYS_W-1:0] actMap, cp1Map, cp2Map;
  logic [ARCH_REGS-1:0]             actMod, cp2Mod;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        actMap[i] <= PHYS_W'(i);
        cp1Map[i] <= PHYS_W'(i);
        cp2Map[i] <= PHYS_W'(i);
      end
      actMod <= '0;
      cp2Mod <= '0;
    end else if (strobe.snapEntry) begin
      cp1Map <= actMap;
      actMod <= '0;
    end else if (strobe.snapAlt) begin
      cp2Map <= actMap;
      cp2Mod <= actMod;
      actMap <= cp1Map;
      actMod <= '0;
    end else begin
      if (strobe.renWr) begin
        actMap[renArch] <= renPhys;
        if (strobe.markMod) actMod[renArch] <= 1'b1;
      end
      for (int k = 0; k < SEL_PORTS; k++) begin
        if (fireVec[k]) begin
          actMap[fireArch[k]] <= freePhys[k];
          actMod[fireArch[k]] <= 1'b0;
          cp2Mod[fireArch[k]] <= 1'b0;
        end
      end
    end
  end

  assign mergeMask = actMod | cp2Mod;
  assign rdPhys    = actMap[rdArch];

  for (genvar k = 0; k < SEL_PORTS; k++) begin : g_port
    assign selSrcPred[k] = cp2Map[fireArch[k]];
    assign selSrcAlt[k]  = actMap[fireArch[k]];

    AST_FIRE_RENAMES_DST: assert property (@(posedge clk) disable iff (!rstN) fireVec[k] |=> (actMap[$past(fireArch[k])] == $past(freePhys[k]) && !mergeMask[$past(fireArch[k])])); // R6
  end

  AST_ENTRY_CLEARS_MOD: assert property (@(posedge clk) disable iff (!rstN) strobe.snapEntry |=> (actMod == '0 && cp1Map == $past(actMap))); // R2
  AST_ALT_RESTORES_MAP: assert property (@(posedge clk) disable iff (!rstN) strobe.snapAlt |=> (actMap == $past(cp1Map) && cp2Mod == $past(actMod) && actMod == '0)); // R3

endmodule

// File: rtl/mergeSelGen.sv
module mergeSelGen
  import mergeSelPkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_W    = 6,
  parameter int PRED_W    = 3,
  parameter int SEL_PORTS = 2,
  localparam int ARCH_W   = $clog2(ARCH_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          renWrEn,
  input  logic [ARCH_W-1:0]             renArch,
  input  logic [PHYS_W-1:0]             renPhys,
  input  logic                          enterPred,
  input  logic [PRED_W-1:0]             enterPredId,
  input  logic                          enterAlt,
  input  logic                          exitPred,
  input  logic [SEL_PORTS-1:0]          freeAvail,
  input  logic [SEL_PORTS*PHYS_W-1:0]   freePhys,
  input  logic [ARCH_W-1:0]             rdArch,
  output logic [PHYS_W-1:0]             rdPhys,
  output logic [SEL_PORTS-1:0]          selValid,
  output logic [SEL_PORTS*ARCH_W-1:0]   selArch,
  output logic [SEL_PORTS*PHYS_W-1:0]   selSrcPred,
  output logic [SEL_PORTS*PHYS_W-1:0]   selSrcAlt,
  output logic [SEL_PORTS*PHYS_W-1:0]   selDst,
  output logic [PRED_W-1:0]             selPredId,
  output logic [SEL_PORTS-1:0]          freeTake,
  output logic                          renStall,
  output logic                          mergeDone
);

  mapStrobe_t                        strobe;
  logic [SEL_PORTS-1:0]              fireVec;
  logic [SEL_PORTS-1:0][ARCH_W-1:0]  fireArch;
  logic [ARCH_REGS-1:0]              mergeMask;

  mergeSelCtl #(
    .ARCH_REGS(ARCH_REGS),
    .SEL_PORTS(SEL_PORTS),
    .PRED_W   (PRED_W),
    .ARCH_W   (ARCH_W)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .renWrEn    (renWrEn),
    .enterPred  (enterPred),
    .enterPredId(enterPredId),
    .enterAlt   (enterAlt),
    .exitPred   (exitPred),
    .freeAvail  (freeAvail),
    .mergeMask  (mergeMask),
    .strobe     (strobe),
    .fireVec    (fireVec),
    .fireArch   (fireArch),
    .selPredId  (selPredId),
    .renStall   (renStall),
    .mergeDone  (mergeDone)
  );

  mergeSelDp #(
    .ARCH_REGS(ARCH_REGS),
    .SEL_PORTS(SEL_PORTS),
    .PHYS_W   (PHYS_W),
    .ARCH_W   (ARCH_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .renArch   (renArch),
    .renPhys   (renPhys),
    .fireVec   (fireVec),
    .fireArch  (fireArch),
    .freePhys  (freePhys),
    .rdArch    (rdArch),
    .rdPhys    (rdPhys),
    .mergeMask (mergeMask),
    .selSrcPred(selSrcPred),
    .selSrcAlt (selSrcAlt)
  );

  assign selValid = fireVec;
  assign freeTake = fireVec;
  assign selArch  = fireArch;
  assign selDst   = freePhys;

endmodule

// File: tb/mergeSelGen_tb.sv
`timescale 1ns/1ps
module mergeSelGen_tb;

  localparam int NA = 8;
  localparam int AW = 3;
  localparam int PW = 6;
  localparam int QW = 3;
  localparam int SP = 2;
  localparam int NPHYS = 64;

  typedef struct {
    int arch;
    int srcP;
    int srcA;
    int pid;
    int dst;
  } selItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic renWrEn = 1'b0;
  logic [AW-1:0] renArch = '0;
  logic [PW-1:0] renPhys = '0;
  logic enterPred = 1'b0;
  logic [QW-1:0] enterPredId = '0;
  logic enterAlt = 1'b0;
  logic exitPred = 1'b0;
  logic [SP-1:0] freeAvail = '1;
  logic [SP*PW-1:0] freePhys;
  logic [AW-1:0] rdArch = '0;
  logic [PW-1:0] rdPhys;
  logic [SP-1:0] selValid;
  logic [SP*AW-1:0] selArch;
  logic [SP*PW-1:0] selSrcPred, selSrcAlt, selDst;
  logic [QW-1:0] selPredId;
  logic [SP-1:0] freeTake;
  logic renStall, mergeDone;

  int nChecks = 0;
  int nFails = 0;
  int freeHead = 16;
  int freeModel = 16;
  bit finished = 1'b0;

  int mAct[NA];
  int mCp1[NA];
  int mCp2[NA];
  bit mModA[NA];
  bit mModC[NA];
  int mMode = 0;
  int mPid = 0;
  selItem_t expQ[$];

  always #4 clk = ~clk;

  mergeSelGen u_dut (
    .clk(clk), .rstN(rstN), .renWrEn(renWrEn), .renArch(renArch), .renPhys(renPhys),
    .enterPred(enterPred), .enterPredId(enterPredId), .enterAlt(enterAlt), .exitPred(exitPred),
    .freeAvail(freeAvail), .freePhys(freePhys), .rdArch(rdArch), .rdPhys(rdPhys),
    .selValid(selValid), .selArch(selArch), .selSrcPred(selSrcPred), .selSrcAlt(selSrcAlt),
    .selDst(selDst), .selPredId(selPredId), .freeTake(freeTake), .renStall(renStall),
    .mergeDone(mergeDone)
  );

  // bench free list: sequential registers, advanced by consumed slots
  always_comb begin
    for (int k = 0; k < SP; k++) freePhys[k*PW +: PW] = PW'((freeHead + k) % NPHYS);
  end
  always @(posedge clk) freeHead <= (freeHead + $countones(freeTake)) % NPHYS;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compare each issued select against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rstN && !finished) begin
      for (int k = 0; k < SP; k++) begin
        if (selValid[k]) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R4", "unexpected select arch", int'(selArch[k*AW +: AW]), -1);
          end else begin
            selItem_t e;
            e = expQ.pop_front();
            check(int'(selArch[k*AW +: AW]) == e.arch, "R5", "select arch order", int'(selArch[k*AW +: AW]), e.arch);
            check(int'(selSrcPred[k*PW +: PW]) == e.srcP, "R4", "predicted-path source", int'(selSrcPred[k*PW +: PW]), e.srcP);
            check(int'(selSrcAlt[k*PW +: PW]) == e.srcA, "R4", "alternate-path source", int'(selSrcAlt[k*PW +: PW]), e.srcA);
            check(int'(selPredId) == e.pid, "R4", "predicate id", int'(selPredId), e.pid);
            check(int'(selDst[k*PW +: PW]) == e.dst, "R6", "destination", int'(selDst[k*PW +: PW]), e.dst);
            check(freeTake[k], "R6", "free slot consumed", int'(freeTake[k]), 1);
            check(freeAvail[k], "R9", "fired with slot available", int'(freeAvail[k]), 1);
          end
        end
      end
    end
  end

  task automatic rename(input int a, input int p);
    @(negedge clk);
    renWrEn = 1'b1; renArch = AW'(a); renPhys = PW'(p);
    mAct[a] = p;
    if (mMode != 0) mModA[a] = 1'b1;
    @(negedge clk);
    renWrEn = 1'b0;
  endtask

  task automatic startRegion(input int pid);
    @(negedge clk);
    enterPred = 1'b1; enterPredId = QW'(pid);
    mPid = pid; mMode = 1;
    foreach (mAct[i]) begin mCp1[i] = mAct[i]; mModA[i] = 1'b0; end
    @(negedge clk);
    enterPred = 1'b0;
  endtask

  task automatic startAlt();
    @(negedge clk);
    enterAlt = 1'b1;
    if (mMode == 1) begin
      foreach (mAct[i]) begin
        mCp2[i] = mAct[i]; mModC[i] = mModA[i];
        mAct[i] = mCp1[i]; mModA[i] = 1'b0;
      end
      mMode = 2;
    end
    @(negedge clk);
    enterAlt = 1'b0;
  endtask

  // pulses exit, pushes expected selects, returns their count
  task automatic exitRegion(output int n);
    n = 0;
    @(negedge clk);
    exitPred = 1'b1;
    for (int a = 0; a < NA; a++) begin
      if (mModA[a] || mModC[a]) begin
        selItem_t e;
        e.arch = a; e.srcP = mCp2[a]; e.srcA = mAct[a]; e.pid = mPid; e.dst = freeModel;
        expQ.push_back(e);
        mAct[a] = freeModel;
        freeModel = (freeModel + 1) % NPHYS;
        mModA[a] = 1'b0; mModC[a] = 1'b0;
        n++;
      end
    end
    mMode = 0;
    @(negedge clk);
    exitPred = 1'b0;
  endtask

  task automatic waitMerge(input int expCycles, input string req);
    int cycles = 0;
    int dones = 0;
    #2;
    while (renStall && cycles < 100) begin
      cycles++;
      if (mergeDone) dones++;
      @(negedge clk);
      #2;
    end
    check(cycles == expCycles, req, "merge cycles", cycles, expCycles);
    check(dones == 1, "R7", "mergeDone pulses", dones, 1);
  endtask

  task automatic checkMap(input string req);
    for (int a = 0; a < NA; a++) begin
      rdArch = AW'(a);
      #0.5;
      check(int'(rdPhys) == mAct[a], req, $sformatf("map entry %0d", a), int'(rdPhys), mAct[a]);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    foreach (mAct[i]) begin mAct[i] = i; mModA[i] = 1'b0; mModC[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1: reset state
    check(!renStall, "R1", "renStall after reset", int'(renStall), 0);
    check(!mergeDone, "R1", "mergeDone after reset", int'(mergeDone), 0);
    check(selValid == '0, "R1", "selValid after reset", int'(selValid), 0);
    checkMap("R1");

    // R2 / R10: idle rename, stray markers ignored
    rename(2, 40);
    startAlt();
    checkMap("R10");
    @(negedge clk);
    exitPred = 1'b1;
    @(negedge clk);
    exitPred = 1'b0;
    #2;
    check(!renStall, "R10", "exit in idle stalls", int'(renStall), 0);
    checkMap("R10");

    // R3 / R4 / R5 / R6: both paths write, one shared register
    startRegion(5);
    rename(1, 41);
    rename(3, 42);
    startAlt();
    checkMap("R3");
    rename(1, 43);
    rename(6, 44);
    exitRegion(n);
    check(n == 3, "R4", "expected select count", n, 3);
    waitMerge(2, "R5");
    checkMap("R6");

    // R8: empty region
    startRegion(2);
    startAlt();
    exitRegion(n);
    waitMerge(1, "R8");
    checkMap("R8");

    // R4 / R5: double writes on a path, four merges
    startRegion(7);
    rename(0, 45);
    rename(7, 46);
    rename(7, 47);
    startAlt();
    rename(4, 48);
    rename(0, 49);
    rename(5, 50);
    exitRegion(n);
    waitMerge(2, "R5");
    checkMap("R6");

    // R9: starved free list, then one slot at a time
    startRegion(1);
    rename(2, 51);
    rename(3, 52);
    startAlt();
    rename(5, 53);
    @(negedge clk);
    freeAvail = 2'b00;
    exitRegion(n);
    repeat (3) begin
      #2;
      check(renStall, "R9", "stall while starved", int'(renStall), 1);
      check(selValid == '0, "R9", "no select while starved", int'(selValid), 0);
      @(negedge clk);
    end
    freeAvail = 2'b01;
    waitMerge(3, "R9");
    freeAvail = 2'b11;
    checkMap("R6");

    @(negedge clk);
    check(expQ.size() == 0, "R4", "selects still outstanding", expQ.size(), 0);
    finishRun();
  end

endmodule